// File: doc/BRIEF.md
# Cascadable Serial-to-Parallel Segment Loader

The loader receives a display segment pattern one bit at a time. A data pin, a serial clock and an active-low select feed a shift chain with one stage per segment, 38 by default. A load strobe then copies the chain into a parallel segment word, which holds the pattern between updates. Three serial taps carry chain positions 30, 32 and the last stage. A tap can feed the data pin of a following loader, so several loaders form a longer chain. The taps also let the shifted pattern be read back and checked.

All serial inputs are oversampled in one fast system clock domain. The serial clock, select, load strobe and data pass through the same synchronizer, so they keep their relative timing. Edges of the serial clock are found from the synchronized copy. The chain shifts on a falling serial edge and the taps move on a rising edge. A downstream loader therefore samples a tap half a serial period after it settled. While the load strobe is high with select low, the segment word follows the chain on every system cycle, so it is transparent rather than edge-captured.

Top module: `seg_loader`

## Requirements
- R1: After reset, `seg_word` is all zeros and `tap_a`, `tap_b` and `tap_end` are 0.
- R2: Each falling edge of `sclk` taken while `cs_n` is low shifts `din` into stage 1 and moves stage k to stage k+1. Stage k is `seg_word[k-1]` after a load. The first of 38 bits shifted in ends in stage 38, which is `seg_word[37]`. The last bit ends in stage 1, which is `seg_word[0]`.
- R3: Falling edges of `sclk` while `cs_n` is high leave the chain unchanged. A later load shows the pattern from before them.
- R4: `tap_a`, `tap_b` and `tap_end` show stages 30, 32 and 38 as they were at the latest rising edge of `sclk`. The taps do not change at a falling edge.
- R5: While `ld` is high and `cs_n` is low, `seg_word` follows the chain. A shift made during that time appears on `seg_word`.
- R6: A pulse on `ld` while `cs_n` is high leaves `seg_word` unchanged.
- R7: While `ld` is low, shifting does not change `seg_word`.
- R8: Two loaders can be chained. The second loader's `din` takes the first loader's `tap_end`, and both share `sclk`, `cs_n` and `ld`. After 76 bits and a load, the first 38 bits sent are in the second loader and the last 38 are in the first, each in the order given by R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than `sclk` |
| rst_n | input | 1 | Asynchronous active-low reset |
| din | input | 1 | Serial segment data |
| sclk | input | 1 | Serial clock; shift on fall, taps on rise |
| cs_n | input | 1 | Active-low select for shifting and loading |
| ld | input | 1 | Load strobe; segment word transparent while high |
| seg_word | output | CHAIN_LEN | Latched segment pattern, bit k-1 = stage k |
| tap_a | output | 1 | Serial tap from stage TAP_A (30) |
| tap_b | output | 1 | Serial tap from stage TAP_B (32) |
| tap_end | output | 1 | Serial tap from the last stage, for cascading |

## Verification
A shift and a latch update can fall in the same system cycle. This happens when a falling serial edge arrives while the load strobe is high, so the shifted value must pass straight through to the segment word. The bench holds `ld` high with `cs_n` low and shifts a run of bits. After each falling edge it compares `seg_word` with the chain contents, which it computes from the history of bits sent. The same run checks that the taps, which move only on rising edges, keep the values they had before that shift.

// File: rtl/seg_loader_pkg.sv
`timescale 1ns/1ps
package seg_loader_pkg;

   // Serial-side control bundle, synchronized as one word so the
   // relative timing of the four pins is preserved.
   typedef struct packed {
      logic din;
      logic sclk;
      logic cs_n;
      logic ld;
   } ctl_t;

   localparam ctl_t CTL_IDLE = '{din: 1'b0, sclk: 1'b0, cs_n: 1'b1, ld: 1'b0};

   localparam int unsigned TAP_FIELD_W = 8;

   function automatic bit tap_in_range(int unsigned pos, int unsigned len);
      return (pos >= 1) && (pos <= len);
   endfunction

endpackage

// File: rtl/seg_sync.sv
`timescale 1ns/1ps
module seg_sync #(
   parameter int unsigned      STAGES  = 2,
   parameter int unsigned      WIDTH   = 1,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("seg_sync needs at least two stages");
      end
   endgenerate

   logic [STAGES-1:0][WIDTH-1:0] pipe;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= {STAGES{RST_VAL}};
      else        pipe <= {pipe[STAGES-2:0], d};
   end

   assign q = pipe[STAGES-1];

endmodule

// File: rtl/seg_shift_chain.sv
`timescale 1ns/1ps
module seg_shift_chain #(
   parameter int unsigned LEN = 38
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           shift_en,
   input  logic           din,
   output logic [LEN-1:0] chain_q
);

   generate
      if (LEN < 2) begin : g_bad_len
         $error("seg_shift_chain needs at least two stages");
      end
      for (genvar i = 0; i < LEN; i++) begin : g_stage
         logic bit_r;
         logic bit_d;
         if (i == 0) begin : g_head
            assign bit_d = din;
         end else begin : g_body
            assign bit_d = chain_q[i-1];
         end
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        bit_r <= 1'b0;
            else if (shift_en) bit_r <= bit_d;
         end
         assign chain_q[i] = bit_r;
      end
   endgenerate

endmodule

// File: rtl/seg_tap_bank.sv
`timescale 1ns/1ps
module seg_tap_bank
   import seg_loader_pkg::*;
#(
   parameter int unsigned                   LEN      = 38,
   parameter int unsigned                   NTAPS    = 3,
   parameter logic [NTAPS*TAP_FIELD_W-1:0]  TAP_LIST = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             update,
   input  logic [LEN-1:0]   chain,
   output logic [NTAPS-1:0] taps
);

   generate
      for (genvar t = 0; t < NTAPS; t++) begin : g_tap
         localparam int unsigned POS = int'(TAP_LIST[t*TAP_FIELD_W +: TAP_FIELD_W]);
         if (!tap_in_range(POS, LEN)) begin : g_bad_pos
            $error("seg_tap_bank tap position outside the chain");
         end
         logic tap_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      tap_r <= 1'b0;
            else if (update) tap_r <= chain[POS-1];
         end
         assign taps[t] = tap_r;
      end
   endgenerate

endmodule

// File: rtl/seg_latch.sv
`timescale 1ns/1ps
module seg_latch #(
   parameter int unsigned LEN            = 38,
   parameter bit          REQUIRE_SELECT = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           ld,
   input  logic           cs_n,
   input  logic [LEN-1:0] d,
   output logic [LEN-1:0] q
);

   logic open_w;

   generate
      if (REQUIRE_SELECT) begin : g_gated
         assign open_w = ld & ~cs_n;
      end else begin : g_free
         logic unused_cs;
         assign unused_cs = cs_n;
         assign open_w    = ld;
      end
   endgenerate

   // Follows the chain every system cycle while open: level transparency.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= '0;
      else if (open_w) q <= d;
   end

endmodule

// File: rtl/seg_loader.sv
`timescale 1ns/1ps
module seg_loader
   import seg_loader_pkg::*;
#(
   parameter int unsigned CHAIN_LEN      = 38,
   parameter int unsigned TAP_A          = 30,
   parameter int unsigned TAP_B          = 32,
   parameter int unsigned SYNC_STAGES    = 2,
   parameter bit          REQUIRE_SELECT = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 din,
   input  logic                 sclk,
   input  logic                 cs_n,
   input  logic                 ld,
   output logic [CHAIN_LEN-1:0] seg_word,
   output logic                 tap_a,
   output logic                 tap_b,
   output logic                 tap_end
);

   localparam int unsigned NTAPS   = 3;
   localparam int unsigned CTL_W   = $bits(ctl_t);
   localparam int unsigned MAX_LEN = (1 << TAP_FIELD_W) - 1;
   localparam logic [NTAPS*TAP_FIELD_W-1:0] TAP_LIST =
      {TAP_FIELD_W'(CHAIN_LEN), TAP_FIELD_W'(TAP_B), TAP_FIELD_W'(TAP_A)};

   generate
      if (CHAIN_LEN > MAX_LEN) begin : g_bad_len
         $error("seg_loader chain longer than the tap field can name");
      end
      if (!tap_in_range(TAP_A, CHAIN_LEN) || !tap_in_range(TAP_B, CHAIN_LEN)) begin : g_bad_tap
         $error("seg_loader tap outside the chain");
      end
   endgenerate

   ctl_t ctl_raw;
   ctl_t ctl_s;
   logic din_s, cs_n_s, ld_s;
   logic sclk_prev, sclk_rise, sclk_fall, shift_en;
   logic [CHAIN_LEN-1:0] chain_q;
   logic [NTAPS-1:0]     tap_q;

   assign ctl_raw = '{din: din, sclk: sclk, cs_n: cs_n, ld: ld};

   seg_sync #(
      .STAGES  (SYNC_STAGES),
      .WIDTH   (CTL_W),
      .RST_VAL (CTL_IDLE)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (ctl_raw),
      .q     (ctl_s)
   );

   assign din_s  = ctl_s.din;
   assign cs_n_s = ctl_s.cs_n;
   assign ld_s   = ctl_s.ld;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_prev <= 1'b0;
      else        sclk_prev <= ctl_s.sclk;
   end

   assign sclk_rise = ~sclk_prev &  ctl_s.sclk;
   assign sclk_fall =  sclk_prev & ~ctl_s.sclk;
   assign shift_en  = sclk_fall & ~cs_n_s;

   seg_shift_chain #(
      .LEN (CHAIN_LEN)
   ) u_chain (
      .clk      (clk),
      .rst_n    (rst_n),
      .shift_en (shift_en),
      .din      (din_s),
      .chain_q  (chain_q)
   );

   seg_tap_bank #(
      .LEN      (CHAIN_LEN),
      .NTAPS    (NTAPS),
      .TAP_LIST (TAP_LIST)
   ) u_taps (
      .clk    (clk),
      .rst_n  (rst_n),
      .update (sclk_rise),
      .chain  (chain_q),
      .taps   (tap_q)
   );

   assign tap_a   = tap_q[0];
   assign tap_b   = tap_q[1];
   assign tap_end = tap_q[2];

   seg_latch #(
      .LEN            (CHAIN_LEN),
      .REQUIRE_SELECT (REQUIRE_SELECT)
   ) u_latch (
      .clk   (clk),
      .rst_n (rst_n),
      .ld    (ld_s),
      .cs_n  (cs_n_s),
      .d     (chain_q),
      .q     (seg_word)
   );

endmodule

// File: rtl/seg_loader_chk.sv
`timescale 1ns/1ps
module seg_loader_chk #(
   parameter int unsigned LEN            = 38,
   parameter int unsigned TAP_A          = 30,
   parameter int unsigned TAP_B          = 32,
   parameter bit          REQUIRE_SELECT = 1'b1
) (
   input logic           clk,
   input logic           rst_n,
   input logic           din_s,
   input logic           cs_n_s,
   input logic           ld_s,
   input logic           sclk_rise,
   input logic           sclk_fall,
   input logic [LEN-1:0] chain_q,
   input logic [LEN-1:0] seg_word,
   input logic [2:0]     tap_q
);

   AST_SHIFT_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk_fall && !cs_n_s) |=> (chain_q == {$past(chain_q[LEN-2:0]), $past(din_s)})); // R2

   AST_DESELECT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n_s |=> $stable(chain_q)); // R3

   AST_TAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !sclk_rise |=> $stable(tap_q)); // R4

   AST_TAP_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
      sclk_rise |=> (tap_q == {$past(chain_q[LEN-1]), $past(chain_q[TAP_B-1]), $past(chain_q[TAP_A-1])})); // R4

   AST_LATCH_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_s && (!REQUIRE_SELECT || !cs_n_s)) |=> (seg_word == $past(chain_q))); // R5

   AST_LOAD_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_s && cs_n_s && REQUIRE_SELECT) |=> $stable(seg_word)); // R6

   AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !ld_s |=> $stable(seg_word)); // R7

endmodule

bind seg_loader seg_loader_chk #(
   .LEN            (CHAIN_LEN),
   .TAP_A          (TAP_A),
   .TAP_B          (TAP_B),
   .REQUIRE_SELECT (REQUIRE_SELECT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .din_s     (din_s),
   .cs_n_s    (cs_n_s),
   .ld_s      (ld_s),
   .sclk_rise (sclk_rise),
   .sclk_fall (sclk_fall),
   .chain_q   (chain_q),
   .seg_word  (seg_word),
   .tap_q     (tap_q)
);

// File: tb/seg_loader_test.sv
`timescale 1ns/1ps
module seg_loader_test;

   localparam int N  = 38;
   localparam int TA = 30;
   localparam int TB = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic din = 1'b0;
   logic sclk = 1'b0;
   logic cs_n = 1'b1;
   logic ld = 1'b0;
   logic [N-1:0] word1, word2;
   logic ta1, tb1, te1, ta2, tb2, te2;

   int  n_cmp = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;
   logic hist [4096];
   int  hcnt = 0;
   logic cbits [2*N];

   always #2.5 clk = ~clk;

   seg_loader uut (
      .clk(clk), .rst_n(rst_n), .din(din), .sclk(sclk), .cs_n(cs_n), .ld(ld),
      .seg_word(word1), .tap_a(ta1), .tap_b(tb1), .tap_end(te1)
   );

   seg_loader uut2 (
      .clk(clk), .rst_n(rst_n), .din(te1), .sclk(sclk), .cs_n(cs_n), .ld(ld),
      .seg_word(word2), .tap_a(ta2), .tap_b(tb2), .tap_end(te2)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   // Stage k (1-based) after all recorded shifts: the bit sent k-1 shifts ago.
   function automatic logic model(input int idx);
      int k;
      k = hcnt - 1 - idx;
      return (k >= 0) ? hist[k] : 1'b0;
   endfunction

   function automatic logic [N-1:0] model_word();
      logic [N-1:0] w;
      for (int i = 0; i < N; i++) w[i] = model(i);
      return w;
   endfunction

   task automatic check_vec(input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic check3(input string tag, input logic [2:0] act, input logic [2:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b", tag, act, exp);
      end
   endtask

   task automatic send_bit(input logic b);
      logic [2:0] et;
      din = b;
      tick(4);
      sclk = 1'b1;
      tick(9);
      et = {model(N-1), model(TB-1), model(TA-1)};
      check3("R4 taps after rising edge", {te1, tb1, ta1}, et);
      tick(1);
      sclk = 1'b0;
      if (!cs_n) begin
         hist[hcnt] = b;
         hcnt++;
      end
      tick(7);
      check3("R4 taps held across falling edge", {te1, tb1, ta1}, et);
   endtask

   task automatic pulse_load();
      ld = 1'b1;
      tick(10);
      ld = 1'b0;
      tick(6);
   endtask

   initial begin
      logic [N-1:0] prev;
      logic [N-1:0] e1, e2;
      tick(4);
      rst_n = 1'b1;
      tick(4);
      check_vec("R1 reset segment word", word1, '0);
      check3("R1 reset taps", {te1, tb1, ta1}, 3'b000);

      // Walking one: bit k of 38 is set; it must land in stage 38-k.
      cs_n = 1'b0;
      tick(4);
      prev = '0;
      for (int k = 0; k < N; k++) begin
         for (int j = 0; j < N; j++) send_bit(j == k);
         check_vec("R7 word held while shifting without load", word1, prev);
         pulse_load();
         prev = N'(1) << (N - 1 - k);
         check_vec("R2 walking-one stage order", word1, prev);
      end

      // Deselected clocks must not move the chain.
      cs_n = 1'b1;
      tick(4);
      for (int j = 0; j < 12; j++) send_bit(1'b1);
      cs_n = 1'b0;
      tick(4);
      pulse_load();
      check_vec("R3 deselected clocks ignored", word1, N'(1));

      // Load with select high must not update the word.
      for (int j = 0; j < N; j++) send_bit((j % 3) == 0);
      cs_n = 1'b1;
      tick(4);
      pulse_load();
      check_vec("R6 load while deselected ignored", word1, N'(1));
      cs_n = 1'b0;
      tick(4);
      pulse_load();
      check_vec("R2 selected load after pattern", word1, model_word());

      // Transparent load: shifts during a high load strobe pass through.
      ld = 1'b1;
      tick(6);
      for (int j = 0; j < 8; j++) begin
         send_bit((j % 2) == 1);
         check_vec("R5 word follows chain while load high", word1, model_word());
      end
      ld = 1'b0;
      tick(6);

      // Cascade of two loaders.
      cs_n = 1'b1;
      tick(2);
      rst_n = 1'b0;
      hcnt = 0;
      tick(3);
      rst_n = 1'b1;
      tick(4);
      check_vec("R1 reset second loader", word2, '0);
      cs_n = 1'b0;
      tick(4);
      for (int j = 0; j < 2*N; j++) begin
         cbits[j] = (((j * 5) + 1) % 7) < 3;
         send_bit(cbits[j]);
      end
      pulse_load();
      for (int i = 0; i < N; i++) begin
         e1[i] = cbits[2*N - 1 - i];
         e2[i] = cbits[N - 1 - i];
      end
      check_vec("R8 cascade first loader", word1, e1);
      check_vec("R8 cascade second loader", word2, e2);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule